// File: doc/BRIEF.md
# Embedded Program Sequencer with Status Read-Back and Hardware Reset

This block takes a single-location program request from the command decoder and carries it out. It runs a timed program phase whose length is set in clock cycles. While the phase runs, it holds the ready/busy line low and answers host reads with a status byte in place of array data. After a successful phase it writes the array word. The block also holds one protect bit per sector. A program request aimed at a protected sector is dropped, unless the temporary-unprotect input is high. If the request would have to raise a cell from 0 to 1, the block does not write the array. Instead it raises a timeout status bit and stays in status mode until the host issues a reset command.

A hardware reset input takes effect on three things. As soon as it is low, the data outputs are disabled and new launches are refused. If it stays low for `RST_MIN` consecutive clock edges, any operation in progress is abandoned without a write. In that case ready/busy stays low for `READY_CYC` more cycles before the block returns to array read.

The array itself is outside the block. The block drives the array read address and expects the read data back in the same cycle. It issues a one-cycle write strobe with address and data when a program completes.

Top module: `prog_status_ctrl`

## Requirements
- R1: After `rst_n` is released, `ready` is 1, `launch_ready` is 1, `prot_map` is all zero and `dq_oe` is 0 while `rd_en` is 0.
- R2: A launch is taken on a clock edge where both `launch_valid` and `launch_ready` are 1. `launch_ready` is 0 whenever `ready` is 0 or `hw_reset_n` is 0. The requester must hold `launch_valid`, `launch_addr` and `launch_data` steady until the launch is taken.
- R3: For a launch to an unprotected sector that lowers or keeps every bit, `ready` is 0 for exactly `PROG_CYC`+1 cycles after the accepting edge. `arr_wr_en` pulses once with the latched address and data. Afterwards a read of that address returns the new data.
- R4: While busy, a read with `rd_en`=1 returns a status byte. Bit 7 is the complement of bit 7 of the data being programmed, and bit 5 is 0 until a timeout. When idle, a read returns `arr_rdata` for `rd_addr`.
- R5: In status mode, bit 6 of the status byte inverts between one read (an `rd_en` high period) and the next.
- R6: While busy, `cmd_reset` and protect-bit writes have no effect. The operation completes as in R3, and `prot_map` is unchanged.
- R7: If the launch data has a 1 where the addressed cell holds a 0, no array write occurs. `TIMEOUT_CYC`+1 cycles after acceptance, status bit 5 reads 1, and `ready` stays 0 until `cmd_reset` is applied. After that the block reads the array again.
- R8: The sector of an address is its top `SW` bits, and `prot_wr_en` sets or clears that sector's bit in `prot_map`. A launch to a protected sector with `tmp_unprotect`=0 is consumed without effect. `ready` stays 1 and the array is unchanged.
- R9: While `tmp_unprotect` is 1, a protected sector can be programmed. Once it returns to 0, the protect bits that are still stored block launches again.
- R10: While `hw_reset_n` is 0, `dq_oe` is 0 and `launch_ready` is 0.
- R11: `hw_reset_n` low for `RST_MIN` consecutive edges during an operation abandons it without an array write. `ready` returns to 1 exactly `READY_CYC` cycles after the aborting edge (this needs `READY_CYC` > `RST_MIN`). A shorter low pulse leaves the operation to complete.
- R12: `hw_reset_n` low while idle keeps `ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous domain reset, active low |
| hw_reset_n | input | 1 | Hardware reset request, active low |
| tmp_unprotect | input | 1 | Lifts all sector protection while high |
| launch_valid | input | 1 | Program request valid |
| launch_ready | output | 1 | Program request can be taken |
| launch_addr | input | AW | Program address |
| launch_data | input | DW | Program data |
| cmd_reset | input | 1 | Reset command pulse, leaves the timeout state |
| prot_wr_en | input | 1 | Protect-bit write strobe |
| prot_wr_sector | input | SW | Sector whose protect bit is written |
| prot_wr_val | input | 1 | New protect bit value |
| prot_map | output | 2**SW | Current protect bits, one per sector |
| rd_en | input | 1 | Host read active (chip and output enabled) |
| rd_addr | input | AW | Host read address |
| dq_out | output | DW | Read data or status byte |
| dq_oe | output | 1 | Data output enable |
| ready | output | 1 | 1 when ready, 0 when busy (ready/busy line) |
| arr_addr | output | AW | Array read address |
| arr_rdata | input | DW | Array read data, same cycle |
| arr_wr_en | output | 1 | Array write strobe |
| arr_wr_addr | output | AW | Array write address |
| arr_wr_data | output | DW | Array write data |

## Verification
Programs are tried with data that clears bits from an erased cell (bit 7 set and bit 7 clear), which shows that status bit 7 follows the data rather than a constant. A request that would raise a cleared bit is the pattern that separates the timeout path from a normal completion. Launches go to protected and unprotected sectors, with and without the override. Hardware reset pulses just under and at the minimum width, while busy and while idle, show that abort is decided by pulse length and that idle reset does not create a busy period.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_PROG  = 3'd2,
    ST_FAIL  = 3'd3,
    ST_ABORT = 3'd4
  } psc_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/psc_prot_bank.sv
module psc_prot_bank #(
  parameter int SW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ok,
  input  logic                 prot_wr_en,
  input  logic [SW-1:0]        prot_wr_sector,
  input  logic                 prot_wr_val,
  input  logic                 tmp_unprotect,
  input  logic [SW-1:0]        sect_i,
  output logic [(1<<SW)-1:0]   prot_map,
  output logic                 blocked
);
  localparam int NSECT = 1 << SW;

  // one protect flop per sector; writes land only when the sequencer is idle
  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    always_ff @(posedge clk) begin
      if (!rst_n)
        prot_map[s] <= 1'b0;
      else if (wr_ok && prot_wr_en && (prot_wr_sector == SW'(s)))
        prot_map[s] <= prot_wr_val;
    end
  end

  assign blocked = prot_map[sect_i] && !tmp_unprotect;
endmodule

// File: rtl/psc_seq_fsm.sv
module psc_seq_fsm
  import psc_pkg::*;
#(
  parameter int AW          = 10,
  parameter int DW          = 8,
  parameter int PROG_CYC    = 24,
  parameter int TIMEOUT_CYC = 64,
  parameter int READY_CYC   = 12,
  parameter int RST_MIN     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_reset_n,
  input  logic          launch_valid,
  input  logic [AW-1:0] launch_addr,
  input  logic [DW-1:0] launch_data,
  input  logic          blocked,
  input  logic          cmd_reset,
  input  logic [DW-1:0] arr_rdata,
  output logic          launch_ready,
  output logic          stat_mode,
  output logic          abort_wait,
  output logic [AW-1:0] lat_addr,
  output logic [DW-1:0] lat_data,
  output logic          fail,
  output logic          arr_wr_en
);
  localparam int MAXC = max2(max2(PROG_CYC, TIMEOUT_CYC), READY_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam int RW   = $clog2(RST_MIN + 1);

  psc_state_e    state;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rcnt;
  logic          fail_pend;
  logic          hw_abort;
  logic          accept;
  logic          raise_bits;

  assign hw_abort     = !hw_reset_n && (rcnt == RW'(RST_MIN - 1));
  assign launch_ready = (state == ST_IDLE) && hw_reset_n;
  assign accept       = launch_valid && launch_ready;
  assign raise_bits   = |(lat_data & ~arr_rdata);
  assign stat_mode    = (state == ST_CHECK) || (state == ST_PROG) || (state == ST_FAIL);
  assign abort_wait   = (state == ST_ABORT);
  assign arr_wr_en    = (state == ST_PROG) && (cnt == '0) && !fail_pend && !hw_abort;

  // consecutive low-edge count of the hardware reset, saturating
  always_ff @(posedge clk) begin
    if (!rst_n || hw_reset_n)
      rcnt <= '0;
    else if (rcnt != RW'(RST_MIN))
      rcnt <= rcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      fail_pend <= 1'b0;
      fail      <= 1'b0;
      lat_addr  <= '0;
      lat_data  <= '0;
    end else if (hw_abort) begin
      if (state != ST_IDLE) begin
        state <= ST_ABORT;
        cnt   <= CW'(READY_CYC - 1);
      end
      fail      <= 1'b0;
      fail_pend <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept && !blocked) begin
            lat_addr <= launch_addr;
            lat_data <= launch_data;
            state    <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          fail_pend <= raise_bits;
          cnt       <= raise_bits ? CW'(TIMEOUT_CYC - 1) : CW'(PROG_CYC - 1);
          state     <= ST_PROG;
        end
        ST_PROG: begin
          if (cnt == '0) begin
            if (fail_pend) begin
              fail  <= 1'b1;
              state <= ST_FAIL;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_FAIL: begin
          if (cmd_reset && hw_reset_n) begin
            fail      <= 1'b0;
            fail_pend <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        ST_ABORT: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psc_status_mux.sv
module psc_status_mux #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          hw_reset_n,
  input  logic          stat_mode,
  input  logic          abort_wait,
  input  logic          lat_bit7,
  input  logic          fail,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  logic rd_q;
  logic toggle;
  logic [DW-1:0] status;

  // toggle advances at the end of each read so it is stable within a read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      toggle <= 1'b0;
    end else begin
      rd_q <= rd_en;
      if (rd_q && !rd_en && stat_mode) toggle <= ~toggle;
    end
  end

  always_comb begin
    status    = '0;
    status[7] = ~lat_bit7;
    status[6] = toggle;
    status[5] = fail;
  end

  assign dq_out = stat_mode ? status : arr_rdata;
  assign dq_oe  = rd_en && hw_reset_n && !abort_wait;
endmodule

// File: rtl/prog_status_ctrl.sv
module prog_status_ctrl #(
  parameter int AW          = 10,
  parameter int DW          = 8,
  parameter int SW          = 3,
  parameter int PROG_CYC    = 24,
  parameter int TIMEOUT_CYC = 64,
  parameter int READY_CYC   = 12,
  parameter int RST_MIN     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hw_reset_n,
  input  logic                 tmp_unprotect,
  input  logic                 launch_valid,
  output logic                 launch_ready,
  input  logic [AW-1:0]        launch_addr,
  input  logic [DW-1:0]        launch_data,
  input  logic                 cmd_reset,
  input  logic                 prot_wr_en,
  input  logic [SW-1:0]        prot_wr_sector,
  input  logic                 prot_wr_val,
  output logic [(1<<SW)-1:0]   prot_map,
  input  logic                 rd_en,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        dq_out,
  output logic                 dq_oe,
  output logic                 ready,
  output logic [AW-1:0]        arr_addr,
  input  logic [DW-1:0]        arr_rdata,
  output logic                 arr_wr_en,
  output logic [AW-1:0]        arr_wr_addr,
  output logic [DW-1:0]        arr_wr_data
);
  logic          blocked;
  logic          stat_mode;
  logic          abort_wait;
  logic          fail;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_data;

  psc_prot_bank #(.SW(SW)) prot_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_ok          (launch_ready),
    .prot_wr_en     (prot_wr_en),
    .prot_wr_sector (prot_wr_sector),
    .prot_wr_val    (prot_wr_val),
    .tmp_unprotect  (tmp_unprotect),
    .sect_i         (launch_addr[AW-1 -: SW]),
    .prot_map       (prot_map),
    .blocked        (blocked)
  );

  psc_seq_fsm #(
    .AW(AW), .DW(DW), .PROG_CYC(PROG_CYC), .TIMEOUT_CYC(TIMEOUT_CYC),
    .READY_CYC(READY_CYC), .RST_MIN(RST_MIN)
  ) fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_reset_n   (hw_reset_n),
    .launch_valid (launch_valid),
    .launch_addr  (launch_addr),
    .launch_data  (launch_data),
    .blocked      (blocked),
    .cmd_reset    (cmd_reset),
    .arr_rdata    (arr_rdata),
    .launch_ready (launch_ready),
    .stat_mode    (stat_mode),
    .abort_wait   (abort_wait),
    .lat_addr     (lat_addr),
    .lat_data     (lat_data),
    .fail         (fail),
    .arr_wr_en    (arr_wr_en)
  );

  psc_status_mux #(.DW(DW)) mux_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .hw_reset_n (hw_reset_n),
    .stat_mode  (stat_mode),
    .abort_wait (abort_wait),
    .lat_bit7   (lat_data[7]),
    .fail       (fail),
    .arr_rdata  (arr_rdata),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe)
  );

  // latched address owns the array port only while the operation is live
  assign arr_addr    = stat_mode ? lat_addr : rd_addr;
  assign arr_wr_addr = lat_addr;
  assign arr_wr_data = lat_data;
  assign ready       = !(stat_mode || abort_wait);
endmodule

// File: rtl/prog_status_ctrl_checker.sv
module prog_status_ctrl_checker #(
  parameter int AW = 10,
  parameter int DW = 8,
  parameter int SW = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hw_reset_n,
  input logic                tmp_unprotect,
  input logic                launch_valid,
  input logic                launch_ready,
  input logic [AW-1:0]       launch_addr,
  input logic [(1<<SW)-1:0]  prot_map,
  input logic                dq_oe,
  input logic                ready,
  input logic [DW-1:0]       arr_rdata,
  input logic                arr_wr_en,
  input logic [DW-1:0]       arr_wr_data
);
  assert_busy_refuses_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !launch_ready);

  assert_rst_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_reset_n |-> (!dq_oe && !launch_ready));

  assert_no_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |-> ((arr_wr_data & ~arr_rdata) == '0));

  assert_done_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |=> ready);

  assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(launch_valid && launch_ready));

  assert_prot_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_valid && launch_ready && prot_map[launch_addr[AW-1 -: SW]] && !tmp_unprotect)
      |=> (ready && !arr_wr_en));
endmodule

bind prog_status_ctrl prog_status_ctrl_checker #(.AW(AW), .DW(DW), .SW(SW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .hw_reset_n    (hw_reset_n),
  .tmp_unprotect (tmp_unprotect),
  .launch_valid  (launch_valid),
  .launch_ready  (launch_ready),
  .launch_addr   (launch_addr),
  .prot_map      (prot_map),
  .dq_oe         (dq_oe),
  .ready         (ready),
  .arr_rdata     (arr_rdata),
  .arr_wr_en     (arr_wr_en),
  .arr_wr_data   (arr_wr_data)
);

// File: tb/prog_status_ctrl_tb_top.sv
module prog_status_ctrl_tb_top;
  localparam int AW = 10, DW = 8, SW = 3;
  localparam int PROG_CYC = 24, TIMEOUT_CYC = 64, READY_CYC = 12, RST_MIN = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, hw_reset_n = 1'b1, tmp_unprotect = 1'b0;
  logic launch_valid = 1'b0, launch_ready;
  logic [AW-1:0] launch_addr = '0;
  logic [DW-1:0] launch_data = '0;
  logic cmd_reset = 1'b0, prot_wr_en = 1'b0, prot_wr_val = 1'b0;
  logic [SW-1:0] prot_wr_sector = '0;
  logic [(1<<SW)-1:0] prot_map;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe, ready;
  logic [AW-1:0] arr_addr, arr_wr_addr;
  logic [DW-1:0] arr_rdata, arr_wr_data;
  logic arr_wr_en;

  prog_status_ctrl #(
    .AW(AW), .DW(DW), .SW(SW), .PROG_CYC(PROG_CYC), .TIMEOUT_CYC(TIMEOUT_CYC),
    .READY_CYC(READY_CYC), .RST_MIN(RST_MIN)
  ) dut_i (.*);

  // external array model, erased to all ones
  logic [DW-1:0] mem [1<<AW];
  initial for (int i = 0; i < (1<<AW); i++) mem[i] = '1;
  assign arr_rdata = mem[arr_addr];
  always @(posedge clk) if (arr_wr_en) mem[arr_wr_addr] <= arr_wr_data;

  typedef struct { logic [DW-1:0] exp; logic [DW-1:0] mask; logic oe; string tag; } exp_t;
  exp_t exp_q[$];
  logic sample_req = 1'b0;
  logic [DW-1:0] last_dq;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // monitor: pops one expectation per read and compares it at the falling edge
  initial forever begin
    @(negedge clk);
    if (sample_req && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      last_dq = dq_out;
      if (dq_oe !== e.oe || (e.oe && ((dq_out & e.mask) !== (e.exp & e.mask)))) begin
        n_bad++;
        $display("FAIL %s: oe=%0b dq=%h expected oe=%0b dq=%h mask=%h",
                 e.tag, dq_oe, dq_out, e.oe, e.exp, e.mask);
      end
      sample_req = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e,
                    input logic [DW-1:0] m, input logic oe, input string tag);
    exp_t x;
    x.exp = e; x.mask = m; x.oe = oe; x.tag = tag;
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(x);
    sample_req = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic launch(input logic [AW-1:0] a, input logic [DW-1:0] d);
    launch_valid = 1'b1; launch_addr = a; launch_data = d;
    @(posedge clk); #1;
    launch_valid = 1'b0;
  endtask

  task automatic wait_ready(output int n, input int limit);
    n = 0;
    while (!ready && n < limit) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  task automatic prot_set(input logic [SW-1:0] s, input logic v);
    prot_wr_en = 1'b1; prot_wr_sector = s; prot_wr_val = v;
    @(posedge clk); #1;
    prot_wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk(ready === 1'b1, "R1 ready", ready, 1);
    chk(launch_ready === 1'b1, "R1 launch_ready", launch_ready, 1);
    chk(prot_map === '0, "R1 prot_map", prot_map, 0);
    chk(dq_oe === 1'b0, "R1 dq_oe", dq_oe, 0);
    rd(10'h005, 8'hFF, 8'hFF, 1'b1, "R4 idle array read");

    // R3 R4 R5 R6: program 0x005 <- 0xA5 with status reads during busy
    launch(10'h005, 8'hA5);
    chk(ready === 1'b0, "R3 busy after accept", ready, 0);
    chk(launch_ready === 1'b0, "R2 refused while busy", launch_ready, 0);
    rd(10'h005, 8'h00, 8'hA0, 1'b1, "R4 status bit7 complement, bit5 clear");
    rd(10'h005, {1'b0, ~last_dq[6], 6'b0}, 8'h40, 1'b1, "R5 toggle inverts");
    cmd_reset = 1'b1; prot_wr_en = 1'b1; prot_wr_sector = 3'd0; prot_wr_val = 1'b1;
    @(posedge clk); #1;
    cmd_reset = 1'b0; prot_wr_en = 1'b0;
    chk(ready === 1'b0, "R6 reset command ignored while busy", ready, 0);
    wait_ready(n, 1000);
    chk(n + 5 == PROG_CYC + 1, "R3 busy length", n + 5, PROG_CYC + 1);
    chk(prot_map === '0, "R6 protect write ignored while busy", prot_map, 0);
    rd(10'h005, 8'hA5, 8'hFF, 1'b1, "R3 programmed data read back");

    // second pattern: bit 7 clear in the data
    launch(10'h2F0, 8'h00);
    rd(10'h2F0, 8'h80, 8'hA0, 1'b1, "R4 status bit7 complement of 0");
    wait_ready(n, 1000);
    rd(10'h2F0, 8'h00, 8'hFF, 1'b1, "R3 zero programmed");

    // R7 attempt to raise bits in 0x005 (holds 0xA5)
    launch(10'h005, 8'hFF);
    repeat (TIMEOUT_CYC + 2) @(posedge clk);
    #1;
    rd(10'h005, 8'h20, 8'hA0, 1'b1, "R7 timeout bit set");
    repeat (20) @(posedge clk);
    #1;
    chk(ready === 1'b0, "R7 stays busy until reset command", ready, 0);
    cmd_reset = 1'b1;
    @(posedge clk); #1;
    cmd_reset = 1'b0;
    chk(ready === 1'b1, "R7 reset command returns to read", ready, 1);
    rd(10'h005, 8'hA5, 8'hFF, 1'b1, "R7 array unchanged");

    // R8 R9 protection (sector = addr[9:7]; 0x105 is sector 2)
    prot_set(3'd2, 1'b1);
    chk(prot_map === 8'h04, "R8 protect bit stored", prot_map, 4);
    launch(10'h105, 8'h00);
    chk(ready === 1'b1, "R8 protected launch dropped", ready, 1);
    rd(10'h105, 8'hFF, 8'hFF, 1'b1, "R8 array unchanged");
    tmp_unprotect = 1'b1;
    launch(10'h105, 8'h3C);
    chk(ready === 1'b0, "R9 override allows program", ready, 0);
    wait_ready(n, 1000);
    tmp_unprotect = 1'b0;
    rd(10'h105, 8'h3C, 8'hFF, 1'b1, "R9 override data written");
    launch(10'h106, 8'h00);
    chk(ready === 1'b1, "R9 protection restored", ready, 1);
    rd(10'h106, 8'hFF, 8'hFF, 1'b1, "R9 restored sector unchanged");

    // R10 R11 short pulse during program: no abort
    launch(10'h030, 8'h55);
    hw_reset_n = 1'b0; rd_en = 1'b1;
    #1;
    chk(dq_oe === 1'b0, "R10 outputs off in reset", dq_oe, 0);
    chk(launch_ready === 1'b0, "R10 launch refused in reset", launch_ready, 0);
    repeat (RST_MIN - 1) @(posedge clk);
    #1 hw_reset_n = 1'b1; rd_en = 1'b0;
    wait_ready(n, 1000);
    rd(10'h030, 8'h55, 8'hFF, 1'b1, "R11 short pulse lets program finish");

    // R11 long pulse during program: abort
    launch(10'h020, 8'h0F);
    hw_reset_n = 1'b0;
    repeat (2 * RST_MIN) @(posedge clk);
    #1;
    chk(ready === 1'b0, "R11 busy held through reset", ready, 0);
    hw_reset_n = 1'b1;
    wait_ready(n, 1000);
    chk(n == READY_CYC - RST_MIN, "R11 ready delay after abort", n, READY_CYC - RST_MIN);
    rd(10'h020, 8'hFF, 8'hFF, 1'b1, "R11 aborted cell unchanged");

    // R12 reset while idle
    hw_reset_n = 1'b0;
    repeat (2 * RST_MIN) @(posedge clk);
    #1;
    chk(ready === 1'b1, "R12 idle reset keeps ready", ready, 1);
    hw_reset_n = 1'b1;
    @(posedge clk); #1;
    chk(ready === 1'b1, "R12 ready after idle reset", ready, 1);
    rd(10'h005, 8'hA5, 8'hFF, 1'b1, "R12 read mode after reset");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule